// File: doc/BRIEF.md
# Debug System Bus Access Engine

This block gives an external debugger a path into system memory without involving a processor. The debugger sees three registers: a control/status register, an address register and a data register. It drives them through a simple register port with a select, a write strobe, a read strobe and a registered read-data return. The engine turns register activity into single transactions on a valid/ready master port. That port carries an access size, an address, write data, and a one-cycle response with read data and an error flag.

Accesses are 8, 16 or 32 bits wide. Sub-word writes replicate the written bytes across the whole bus word, and sub-word reads pick the addressed byte lanes and return them zero-extended. A read can be launched by writing the address register, by reading the data register, or both. After each successful access the address can advance by the access size.

The engine keeps a busy flag, a sticky busy-violation flag and a 3-bit error code. While either error indication is set, no transfer starts and data-register writes are dropped. A failed access leaves the address and the data register untouched.

Top module: `dbg_sysbus_engine`

## Requirements
- R1: After reset the control register reads 0x0000_0002 (word size, all options off, no flags), and the address and data registers read 0.
- R2: Control layout: bits [2:0] size (0 byte, 1 half, 2 word), bit 4 read on address write, bit 5 read on data read, bit 6 auto-increment, bit 8 busy (read-only), bit 9 busy violation, bits [14:12] error code. Register select 0 is control, 1 is address, 2 is data.
- R3: A data-register write starts a bus write at the current address and size. The bus data holds the low byte repeated four times for byte size, the low half repeated twice for half size, and the full word for word size.
- R4: When a read completes, the data register receives the addressed lanes of the bus word, shifted to bit 0 and zero-extended to 32 bits.
- R5: If a transfer would start with a size code above 2, the error code becomes 4. If the address is not a multiple of the access size, the error code becomes 3. In both cases no bus request is issued.
- R6: With read-on-address-write set, an address write starts a read, and its alignment check uses the newly written address.
- R7: With read-on-data-read set, a data-register read returns the current value and then starts a read.
- R8: With auto-increment set, the address grows by the access size in bytes after each successful access.
- R9: A bus error response sets error code 2. The address does not advance, and read data from the failed access is not stored.
- R10: While busy, any address write and any data-register read or write sets the busy-violation flag and leaves the address and data registers unchanged.
- R11: While the error code is nonzero or the busy-violation flag is set, data-register writes are ignored and no transfer starts, whatever the trigger.
- R12: Writing 1 to an error-code bit clears that bit, and writing 1 to bit 9 clears the busy-violation flag.
- R13: A bus request keeps its address, size, direction and data stable until it is accepted by ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Register write value |
| reg_rdata | output | DATA_W | Registered read value, valid the cycle after reg_ren |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_write | output | 1 | 1 write, 0 read |
| bus_size | output | 3 | Access size code |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | DATA_W | Lane-replicated write data |
| bus_resp_valid | input | 1 | One-cycle response strobe |
| bus_rdata | input | DATA_W | Response read word |
| bus_err | input | 1 | Response error flag |

## Verification
The bench sweeps every size against every byte offset, for both writes and reads, and computes the lane placement and the alignment outcome arithmetically. A design that replicates or extracts the wrong lanes, or that checks alignment against a stale address, shows up as wrong memory bytes or a wrong error code. Error-region accesses check that the address holds and that the data register keeps its old value; a design that increments anyway or stores the failed read data is caught. Stalling the bus checks that violations raised while busy stick, and that later triggers are blocked until the flag is cleared by writing 1; a design that lets a transfer slip through is caught by counting requests.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RESP} dsb_state_e;
  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_BUS   = 3'd2;
  localparam logic [2:0] ERR_ALIGN = 3'd3;
  localparam logic [2:0] ERR_SIZE  = 3'd4;
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_DATA  = 2'd2;
endpackage

// File: rtl/dsb_access_check.sv
module dsb_access_check #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [2:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              size_ok,
  output logic              aligned,
  output logic [ADDR_W-1:0] step
);
  localparam int LANES    = DATA_W / 8;
  localparam int LB       = $clog2(LANES);
  localparam int MAX_SIZE = LB;

  always_comb begin
    size_ok = (int'(size) <= MAX_SIZE);
    aligned = 1'b1;
    for (int b = 0; b < LB; b++) begin
      if ((b < int'(size)) && addr[b]) aligned = 1'b0;
    end
    step = ADDR_W'(1) << size;
  end
endmodule

// File: rtl/dsb_lane_steer.sv
module dsb_lane_steer #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]                      size,
  input  logic [$clog2(DATA_W/8)-1:0]     offset,
  input  logic [DATA_W-1:0]               wdata,
  input  logic [DATA_W-1:0]               rdata_bus,
  output logic [DATA_W-1:0]               wdata_bus,
  output logic [DATA_W-1:0]               rdata_val
);
  localparam int LANES = DATA_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      case (size)
        3'd0:    wdata_bus[8*i +: 8] = wdata[7:0];
        3'd1:    wdata_bus[8*i +: 8] = wdata[8*(i % 2) +: 8];
        default: wdata_bus[8*i +: 8] = wdata[8*i +: 8];
      endcase
    end
  end

  logic [DATA_W-1:0] shifted;
  always_comb begin
    shifted   = rdata_bus >> {offset, 3'b000};
    rdata_val = '0;
    case (size)
      3'd0:    rdata_val[7:0]  = shifted[7:0];
      3'd1:    rdata_val[15:0] = shifted[15:0];
      default: rdata_val       = shifted;
    endcase
  end
endmodule

// File: rtl/dbg_sysbus_engine.sv
module dbg_sysbus_engine
  import dsb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wen,
  input  logic              reg_ren,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_write,
  output logic [2:0]        bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_resp_valid,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);
  localparam int LB = $clog2(DATA_W / 8);

  dsb_state_e        state_q;
  logic [2:0]        size_q, xfer_size_q, err_q;
  logic              rd_on_addr_q, rd_on_data_q, autoinc_q, busyerr_q, xfer_write_q;
  logic [ADDR_W-1:0] addr_q, step_q;
  logic [DATA_W-1:0] data_q;

  logic busy, no_err, wen_ctrl, wen_addr, wen_data, ren_data;
  logic start_wr, start_rd, start_any;
  logic [ADDR_W-1:0] start_addr, chk_step;
  logic chk_size_ok, chk_aligned;
  logic [DATA_W-1:0] rd_val, ctrl_view;

  assign busy     = (state_q != ST_IDLE);
  assign no_err   = (err_q == ERR_NONE) && !busyerr_q;
  assign wen_ctrl = reg_wen && (reg_sel == SEL_CTRL);
  assign wen_addr = reg_wen && (reg_sel == SEL_ADDR);
  assign wen_data = reg_wen && (reg_sel == SEL_DATA);
  assign ren_data = reg_ren && (reg_sel == SEL_DATA);

  assign start_wr   = wen_data && !busy && no_err;
  assign start_rd   = !busy && no_err && ((wen_addr && rd_on_addr_q) || (ren_data && rd_on_data_q));
  assign start_any  = start_wr || start_rd;
  assign start_addr = wen_addr ? reg_wdata[ADDR_W-1:0] : addr_q;

  dsb_access_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_check (
    .size    (size_q),
    .addr    (start_addr),
    .size_ok (chk_size_ok),
    .aligned (chk_aligned),
    .step    (chk_step)
  );

  dsb_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .size      (xfer_size_q),
    .offset    (addr_q[LB-1:0]),
    .wdata     (data_q),
    .rdata_bus (bus_rdata),
    .wdata_bus (bus_wdata),
    .rdata_val (rd_val)
  );

  always_comb begin
    ctrl_view        = '0;
    ctrl_view[2:0]   = size_q;
    ctrl_view[4]     = rd_on_addr_q;
    ctrl_view[5]     = rd_on_data_q;
    ctrl_view[6]     = autoinc_q;
    ctrl_view[8]     = busy;
    ctrl_view[9]     = busyerr_q;
    ctrl_view[14:12] = err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      size_q       <= 3'd2;
      xfer_size_q  <= 3'd2;
      rd_on_addr_q <= 1'b0;
      rd_on_data_q <= 1'b0;
      autoinc_q    <= 1'b0;
      busyerr_q    <= 1'b0;
      err_q        <= ERR_NONE;
      xfer_write_q <= 1'b0;
      addr_q       <= '0;
      step_q       <= '0;
      data_q       <= '0;
      reg_rdata    <= '0;
    end else begin
      if (reg_ren) begin
        case (reg_sel)
          SEL_CTRL: reg_rdata <= ctrl_view;
          SEL_ADDR: reg_rdata <= DATA_W'(addr_q);
          SEL_DATA: reg_rdata <= data_q;
          default:  reg_rdata <= '0;
        endcase
      end
      if (wen_ctrl) begin
        size_q       <= reg_wdata[2:0];
        rd_on_addr_q <= reg_wdata[4];
        rd_on_data_q <= reg_wdata[5];
        autoinc_q    <= reg_wdata[6];
        if (reg_wdata[9]) busyerr_q <= 1'b0;
        err_q <= err_q & ~reg_wdata[14:12];
      end
      if (busy && (wen_addr || wen_data || ren_data)) busyerr_q <= 1'b1;
      if (wen_addr && !busy) addr_q <= reg_wdata[ADDR_W-1:0];
      if (start_wr) data_q <= reg_wdata;
      case (state_q)
        ST_IDLE: begin
          if (start_any) begin
            if (!chk_size_ok) begin
              err_q <= ERR_SIZE;
            end else if (!chk_aligned) begin
              err_q <= ERR_ALIGN;
            end else begin
              state_q      <= ST_REQ;
              xfer_write_q <= start_wr;
              xfer_size_q  <= size_q;
              step_q       <= chk_step;
            end
          end
        end
        ST_REQ: begin
          if (bus_req_ready) state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (bus_resp_valid) begin
            state_q <= ST_IDLE;
            if (bus_err) begin
              err_q <= ERR_BUS;
            end else begin
              if (!xfer_write_q) data_q <= rd_val;
              if (autoinc_q) addr_q <= addr_q + step_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_valid = (state_q == ST_REQ);
  assign bus_write     = xfer_write_q;
  assign bus_size      = xfer_size_q;
  assign bus_addr      = addr_q;

  // R13: request held stable while stalled
  a_r13_req_stable: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_addr)
      && $stable(bus_wdata) && $stable(bus_size) && $stable(bus_write));

  // R11: a request only rises when no error indication was present
  a_r11_no_start_on_err: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req_valid) |-> $past(err_q == ERR_NONE && !busyerr_q));

  // R9: failed response keeps the address and records the bus error
  a_r9_no_incr_on_err: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESP) && bus_resp_valid && bus_err |=> $stable(addr_q) && (err_q == ERR_BUS));

  // R10: address write while busy flags a violation
  a_r10_busy_addr_write: assert property (@(posedge clk) disable iff (rst)
    busy && wen_addr |=> busyerr_q);

  // R10: data register untouched while a request is outstanding
  a_r10_data_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REQ) |=> $stable(data_q));
endmodule

// File: tb/dbg_sysbus_engine_test.sv
module dbg_sysbus_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_sel = '0;
  logic        reg_wen = 1'b0, reg_ren = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        bus_req_valid, bus_write, bus_req_ready;
  logic [2:0]  bus_size;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_resp_valid = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        stall = 1'b0;
  int          req_count = 0;
  logic [31:0] last_wdata = '0;
  logic [7:0]  mem [64];
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;
  assign bus_req_ready = !stall;

  dbg_sysbus_engine uut (.*);

  always @(posedge clk) begin
    bus_resp_valid <= 1'b0;
    if (bus_req_valid && bus_req_ready) begin
      req_count      <= req_count + 1;
      bus_resp_valid <= 1'b1;
      bus_err        <= bus_addr[8];
      bus_rdata      <= {mem[{bus_addr[5:2], 2'd3}], mem[{bus_addr[5:2], 2'd2}],
                         mem[{bus_addr[5:2], 2'd1}], mem[{bus_addr[5:2], 2'd0}]};
      if (bus_write) begin
        last_wdata <= bus_wdata;
        if (!bus_addr[8])
          for (int k = 0; k < (1 << bus_size); k++)
            mem[6'(bus_addr[5:0] + 6'(k))] <= bus_wdata[8*(bus_addr[1:0] + 2'(k)) +: 8];
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk); reg_wen = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_ren = 1'b1;
    @(negedge clk); reg_ren = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 50; i++) begin
      rd(2'd0, c);
      if (!c[8]) break;
    end
  endtask

  function automatic logic [31:0] cfg(int sz, bit ra, bit rdd, bit inc);
    return 32'(sz) | (32'(ra) << 4) | (32'(rdd) << 5) | (32'(inc) << 6);
  endfunction

  initial begin
    logic [31:0] v, p, e, rep;
    int b, cnt;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(2'd0, v); chk("R1 ctrl reset", v, 32'h2);
    rd(2'd1, v); chk("R1 addr reset", v, 32'h0);
    rd(2'd2, v); chk("R1 data reset", v, 32'h0);

    for (int s = 0; s < 3; s++) begin
      for (int o = 0; o < 4; o++) begin
        b = 1 << s;
        p = 32'hA1B2C3D4 ^ 32'(s * 16 + o);
        wr(2'd0, cfg(s, 0, 0, 1));
        wr(2'd1, 32'h10 + 32'(o));
        cnt = req_count;
        wr(2'd2, p);
        wait_idle();
        if (o % b == 0) begin
          rep = (s == 0) ? {4{p[7:0]}} : (s == 1) ? {2{p[15:0]}} : p;
          chk("R3 lane replication", last_wdata, rep);
          e = '0; v = '0;
          for (int k = 0; k < b; k++) begin
            v[8*k +: 8] = mem[16 + o + k];
            e[8*k +: 8] = p[8*k +: 8];
          end
          chk("R3 memory bytes", v, e);
          rd(2'd1, v); chk("R8 autoinc step", v, 32'h10 + 32'(o + b));
          for (int k = 0; k < b; k++) mem[16 + o + k] = 8'(k * 29 + o + s);
          wr(2'd0, cfg(s, 1, 0, 0));
          wr(2'd1, 32'h10 + 32'(o));
          wait_idle();
          e = '0;
          for (int k = 0; k < b; k++) e[8*k +: 8] = mem[16 + o + k];
          rd(2'd2, v); chk("R4 read lane extract", v, e);
          rd(2'd1, v); chk("R6 no increment when off", v, 32'h10 + 32'(o));
        end else begin
          rd(2'd0, v); chk("R5 align error code", 32'(v[14:12]), 32'd3);
          chk("R5 no request", 32'(req_count), 32'(cnt));
          rd(2'd1, v); chk("R5 addr kept", v, 32'h10 + 32'(o));
          wr(2'd0, cfg(s, 1, 0, 0) | 32'h7000);
          cnt = req_count;
          wr(2'd1, 32'h10 + 32'(o & ~(b - 1)) + 32'(b));
          wait_idle();
          rd(2'd0, v); chk("R6 new address checked", 32'(v[14:12]), 32'd0);
          chk("R6 read issued", 32'(req_count), 32'(cnt + 1));
          wr(2'd0, cfg(s, 0, 0, 0));
        end
      end
    end

    // unsupported size
    wr(2'd0, cfg(3, 0, 0, 0));
    cnt = req_count;
    wr(2'd2, 32'h1);
    rd(2'd0, v); chk("R5 size error code", 32'(v[14:12]), 32'd4);
    chk("R5 size no request", 32'(req_count), 32'(cnt));
    wr(2'd0, cfg(2, 0, 0, 0) | 32'h7000);
    rd(2'd0, v); chk("R12 error cleared", v, 32'h2);
    chk("R2 layout word size", 32'(v[2:0]), 32'd2);

    // bus error
    wr(2'd0, cfg(2, 0, 0, 1));
    wr(2'd1, 32'h100);
    wr(2'd2, 32'h5555AAAA);
    wait_idle();
    rd(2'd0, v); chk("R9 bus error code", 32'(v[14:12]), 32'd2);
    rd(2'd1, v); chk("R9 addr not advanced", v, 32'h100);
    wr(2'd0, cfg(2, 1, 0, 1) | 32'h7000);
    wr(2'd1, 32'h104);
    wait_idle();
    rd(2'd2, v); chk("R9 failed read discarded", v, 32'h5555AAAA);
    cnt = req_count;
    wr(2'd2, 32'h12345678);
    rd(2'd2, v); chk("R11 data write ignored on error", v, 32'h5555AAAA);
    wr(2'd1, 32'h8);
    chk("R11 no start on error", 32'(req_count), 32'(cnt));
    wr(2'd0, cfg(2, 0, 0, 0) | 32'h2000);
    rd(2'd0, v); chk("R12 partial clear", 32'(v[14:12]), 32'd0);

    // read on data read
    wr(2'd0, cfg(2, 0, 1, 1));
    wr(2'd1, 32'h0);
    rd(2'd2, v); chk("R7 returns old value", v, 32'h5555AAAA);
    wait_idle();
    rd(2'd2, v); chk("R7 fetched word", v, {mem[3], mem[2], mem[1], mem[0]});
    wait_idle();
    rd(2'd1, v); chk("R8 two increments", v, 32'h8);

    // busy violation
    wr(2'd0, cfg(2, 0, 0, 0));
    wr(2'd1, 32'h20);
    stall = 1'b1;
    wr(2'd2, 32'hCAFEF00D);
    wr(2'd1, 32'h24);
    rd(2'd0, v); chk("R10 busy and violation", 32'(v[9:8]), 32'd3);
    stall = 1'b0;
    wait_idle();
    rd(2'd1, v); chk("R10 addr kept while busy", v, 32'h20);
    chk("R13 stalled write landed", {mem[35], mem[34], mem[33], mem[32]}, 32'hCAFEF00D);
    cnt = req_count;
    wr(2'd2, 32'h0BADBEEF);
    rd(2'd2, v); chk("R11 write ignored on violation", v, 32'hCAFEF00D);
    chk("R11 no request on violation", 32'(req_count), 32'(cnt));
    wr(2'd0, cfg(2, 0, 0, 0) | 32'h200);
    rd(2'd0, v); chk("R12 violation cleared", v, 32'h2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule